// File: doc/BRIEF.md
# Reloadable Countdown Timer Bank

This peripheral holds three independent down-counters and one long free-running up-counter behind a 32-bit single-cycle register bus. Software programs each down-counter with a start or reload value, a timebase choice and a mode. The counter then decrements on each qualifying tick and raises a level interrupt every time it steps past zero. In periodic mode the counter returns to the programmed value, so a value of N gives one interrupt every N+1 ticks. In free-run mode it wraps to all ones instead. The first two counters are narrow and the third is 32 bits wide.

Two single-cycle strobes, `slow_tick` and `fast_tick`, stand in for the two timebases. The long counter advances on `fast_tick` whenever its enable bit is set. It is read as a low word and a high byte, and it never interrupts. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. Writes take effect at the clock edge on which `bus_we` is high.

Top module: `tmr_bank_top`

## Requirements
- R1: After reset every register reads zero, all three interrupt outputs are low and no counter moves.
- R2: The register groups of the down-counters start at byte addresses 0x00, 0x20 and 0x80. Within a group, +0x0 holds the reload value, +0x4 the live count, +0x8 the control word and +0xC the interrupt clear. The long counter's low word is at 0x60 and its high register is at 0x64. Any other address reads zero.
- R3: Control bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the fast timebase. All other control bits read back as zero. A counter with bit 7 clear holds its value whatever ticks arrive.
- R4: A write to the reload register copies the value into both the reload register and the live count at that clock edge. A tick in the same cycle is discarded and cannot raise the interrupt.
- R5: In periodic mode a counter loaded with N steps through N, N-1, ..., 0 and then returns to N, flagging its interrupt on that step, so it underflows once every N+1 ticks.
- R6: In free-run mode (bit 6 clear) a counter at zero wraps to all ones on the next tick and still flags its interrupt.
- R7: Each interrupt output is a level that is set on the underflow tick. A write of any data to the channel's clear register drops it. If an underflow and a clear write fall in the same cycle, the interrupt stays set.
- R8: Counters 1 and 2 are T12_W bits wide and counter 3 is T3_W bits wide. The bits above a counter's width read zero in its reload and count registers, and written bits above that width are dropped.
- R9: With bit 3 set a counter advances only on `fast_tick`. With bit 3 clear it advances only on `slow_tick`.
- R10: The long counter is FREE_W bits wide and counts up by one on each `fast_tick` while bit 8 of the high register is set. It never reloads. 0x60 returns its low 32 bits. 0x64 returns its upper bits in bits 7:0 and the run enable in bit 8.
- R11: Writes to a live-count register or to the long counter's low word change nothing. A write to 0x64 changes only the run enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow timebase strobe, one cycle per tick |
| fast_tick | input | 1 | Fast timebase strobe, one cycle per tick |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Level interrupts of down-counters 1..3 (bit 0 = counter 1) |

## Verification
The bench builds the block with T12_W = 12, T3_W = 32 and FREE_W = 40. The narrow counters are therefore 12 bits wide. This makes the upper-bit masking visible on a full-ones write, and a free-run wrap to 0xFFF is a short step. The 32-bit counter keeps its full width, which puts a near-full 32-bit load and its countdown within reach. The 40-bit counter's carry into the high byte cannot be reached in the run. Its enable, low-word count and high-register layout are checked instead.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int ADDR_W       = 8;
  localparam int NUM_CHAN     = 3;
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PER_BIT  = 6;
  localparam int CTL_FAST_BIT = 3;
  localparam int FREE_EN_BIT  = 8;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h0C;
  localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast;
  } chan_ctl_t;

  function automatic logic [ADDR_W-1:0] chan_base(input int idx);
    case (idx)
      0:       chan_base = 8'h00;
      1:       chan_base = 8'h20;
      default: chan_base = 8'h80;
    endcase
  endfunction

  function automatic logic [31:0] ctl_word(input chan_ctl_t c);
    logic [31:0] w;
    w = '0;
    w[CTL_EN_BIT]   = c.run;
    w[CTL_PER_BIT]  = c.periodic;
    w[CTL_FAST_BIT] = c.fast;
    ctl_word = w;
  endfunction
endpackage

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
  import tmr_bank_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic          wr_reload,
  input  logic          wr_ctl,
  input  logic          wr_clr,
  input  logic [CW-1:0] reload_data,
  input  chan_ctl_t     ctl_data,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] count_q,
  output chan_ctl_t     ctl_q,
  output logic          irq_q
);
  localparam logic [CW-1:0] ALL_ONES = '1;

  logic          tick;
  logic          at_zero;
  logic          underflow;
  logic          count_en;
  logic [CW-1:0] count_d;
  logic          irq_d;

  always_comb begin
    tick      = ctl_q.run & (ctl_q.fast ? fast_tick : slow_tick);
    at_zero   = (count_q == '0);
    underflow = tick & at_zero & ~wr_reload;
    count_en  = wr_reload | tick;
    if (wr_reload)     count_d = reload_data;
    else if (!at_zero) count_d = count_q - 1'b1;
    else if (ctl_q.periodic) count_d = reload_q;
    else               count_d = ALL_ONES;
    if (underflow)     irq_d = 1'b1;
    else if (wr_clr)   irq_d = 1'b0;
    else               irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctl_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= reload_data;
      if (count_en)  count_q  <= count_d;
      if (wr_ctl)    ctl_q    <= ctl_data;
      irq_q <= irq_d;
    end
  end

  assert_irq_on_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !wr_reload) |=> irq_q);
  assert_clear_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !(tick && at_zero && !wr_reload)) |=> !irq_q);
  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !wr_reload && ctl_q.periodic) |=> (count_q == $past(reload_q)));
  assert_freerun_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !wr_reload && !ctl_q.periodic) |=> (count_q == ALL_ONES));
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !wr_reload) |=> $stable(count_q));
  assert_reload_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> (count_q == reload_q));
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr #(
  parameter int FW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_tick,
  input  logic          wr_hi,
  input  logic          run_data,
  output logic [FW-1:0] count_q,
  output logic          run_q
);
  logic          step;
  logic [FW-1:0] count_d;

  always_comb begin
    step    = run_q & fast_tick;
    count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      if (step)  count_q <= count_d;
      if (wr_hi) run_q   <= run_data;
    end
  end

  assert_free_increments_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && fast_tick) |=> (count_q == $past(count_q) + 1'b1));
  assert_free_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && fast_tick) |=> $stable(count_q));
endmodule

// File: rtl/tmr_bank_top.sv
module tmr_bank_top
  import tmr_bank_pkg::*;
#(
  parameter int T12_W  = 16,
  parameter int T3_W   = 32,
  parameter int FREE_W = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick,
  input  logic                fast_tick,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CHAN-1:0] irq
);
  localparam int HI_W = FREE_W - 32;

  logic [31:0] reload32 [NUM_CHAN];
  logic [31:0] count32  [NUM_CHAN];
  chan_ctl_t   ctl_v    [NUM_CHAN];
  chan_ctl_t   ctl_wr;
  logic [FREE_W-1:0] free_cnt;
  logic              free_run;
  logic [31:0]       free_hi_word;

  always_comb begin
    ctl_wr.run      = bus_wdata[CTL_EN_BIT];
    ctl_wr.periodic = bus_wdata[CTL_PER_BIT];
    ctl_wr.fast     = bus_wdata[CTL_FAST_BIT];
  end

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    localparam int CW = (i == NUM_CHAN - 1) ? T3_W : T12_W;
    localparam logic [ADDR_W-1:0] BASE = chan_base(i);
    logic [CW-1:0] reload_q;
    logic [CW-1:0] count_q;
    logic          wr_reload;
    logic          wr_ctl;
    logic          wr_clr;

    always_comb begin
      wr_reload = bus_we && (bus_addr == BASE + OFS_RELOAD);
      wr_ctl    = bus_we && (bus_addr == BASE + OFS_CTL);
      wr_clr    = bus_we && (bus_addr == BASE + OFS_CLR);
    end

    tmr_reload_chan #(.CW(CW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .slow_tick   (slow_tick),
      .fast_tick   (fast_tick),
      .wr_reload   (wr_reload),
      .wr_ctl      (wr_ctl),
      .wr_clr      (wr_clr),
      .reload_data (bus_wdata[CW-1:0]),
      .ctl_data    (ctl_wr),
      .reload_q    (reload_q),
      .count_q     (count_q),
      .ctl_q       (ctl_v[i]),
      .irq_q       (irq[i])
    );

    assign reload32[i] = 32'(reload_q);
    assign count32[i]  = 32'(count_q);
  end

  tmr_free_ctr #(.FW(FREE_W)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .wr_hi     (bus_we && (bus_addr == FREE_HI_ADDR)),
    .run_data  (bus_wdata[FREE_EN_BIT]),
    .count_q   (free_cnt),
    .run_q     (free_run)
  );

  always_comb begin
    free_hi_word = '0;
    free_hi_word[HI_W-1:0]   = free_cnt[FREE_W-1:32];
    free_hi_word[FREE_EN_BIT] = free_run;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (bus_addr == chan_base(i) + OFS_RELOAD) bus_rdata = reload32[i];
      if (bus_addr == chan_base(i) + OFS_COUNT)  bus_rdata = count32[i];
      if (bus_addr == chan_base(i) + OFS_CTL)    bus_rdata = ctl_word(ctl_v[i]);
    end
    if (bus_addr == FREE_LO_ADDR) bus_rdata = free_cnt[31:0];
    if (bus_addr == FREE_HI_ADDR) bus_rdata = free_hi_word;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));
  assert_hi_run_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == FREE_HI_ADDR) |=> (free_run == $past(bus_wdata[FREE_EN_BIT])));
endmodule

// File: tb/tb_tmr_bank_top.sv
module tb_tmr_bank_top;
  localparam int T12W = 12;
  localparam longint FREE_MASK = (64'd1 << 40) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick, fast_tick;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_bank_top #(.T12_W(T12W), .T3_W(32), .FREE_W(40)) dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference state
  longint m_load [3];
  longint m_cnt  [3];
  bit     m_en [3], m_per [3], m_fast [3], m_irq [3];
  longint m_free;
  bit     m_fen;

  function automatic longint wmask(int i);
    return (i == 2) ? 64'hFFFF_FFFF : ((64'd1 << T12W) - 1);
  endfunction

  function automatic int gbase(int i);
    return (i == 0) ? 'h00 : (i == 1) ? 'h20 : 'h80;
  endfunction

  function automatic longint mread(int a);
    for (int i = 0; i < 3; i++) begin
      if (a == gbase(i))      return m_load[i];
      if (a == gbase(i) + 4)  return m_cnt[i];
      if (a == gbase(i) + 8)  return (longint'(m_en[i]) << 7) | (longint'(m_per[i]) << 6) | (longint'(m_fast[i]) << 3);
      if (a == gbase(i) + 12) return 0;
    end
    if (a == 'h60) return m_free & 64'hFFFF_FFFF;
    if (a == 'h64) return (longint'(m_fen) << 8) | (m_free >> 32);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_load[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_per[i] = 0; m_fast[i] = 0; m_irq[i] = 0;
      end
      m_free = 0; m_fen = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit tk, st;
        tk = m_en[i] && (m_fast[i] ? fast_tick : slow_tick);
        st = 0;
        if (bus_we && bus_addr == gbase(i)) begin
          m_load[i] = bus_wdata & wmask(i);
          m_cnt[i]  = bus_wdata & wmask(i);
        end else if (tk) begin
          if (m_cnt[i] == 0) begin
            st = 1;
            m_cnt[i] = m_per[i] ? m_load[i] : wmask(i);
          end else m_cnt[i] = m_cnt[i] - 1;
        end
        if (bus_we && bus_addr == gbase(i) + 8) begin
          m_en[i] = bus_wdata[7]; m_per[i] = bus_wdata[6]; m_fast[i] = bus_wdata[3];
        end
        if (st) m_irq[i] = 1;
        else if (bus_we && bus_addr == gbase(i) + 12) m_irq[i] = 0;
      end
      if (m_fen && fast_tick) m_free = (m_free + 1) & FREE_MASK;
      if (bus_we && bus_addr == 8'h64) m_fen = bus_wdata[8];
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every clock: interrupt outputs against the model (R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 3; i++) check("R7", 64'(irq[i]), 64'(m_irq[i]));
    end
  end

  task automatic cyc(bit s, bit f);
    @(negedge clk);
    bus_we = 0; slow_tick = s; fast_tick = f;
  endtask

  task automatic wr(int a, logic [31:0] d, bit s = 0, bit f = 0);
    @(negedge clk);
    bus_we = 1; bus_addr = 8'(a); bus_wdata = d; slow_tick = s; fast_tick = f;
  endtask

  // spends one idle cycle, then reads and compares to the model
  task automatic rd(string req, int a);
    @(negedge clk);
    bus_we = 0; slow_tick = 0; fast_tick = 0; bus_addr = 8'(a);
    #1;
    check(req, 64'(bus_rdata), 64'(mread(a)));
  endtask

  task automatic rdlit(string req, int a, logic [31:0] exp);
    @(negedge clk);
    bus_we = 0; slow_tick = 0; fast_tick = 0; bus_addr = 8'(a);
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; slow_tick = 0; fast_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 / R2: reset values and unmapped addresses
    for (int i = 0; i < 3; i++) begin
      rdlit("R1", gbase(i), 0); rdlit("R1", gbase(i) + 4, 0); rdlit("R1", gbase(i) + 8, 0);
    end
    rdlit("R1", 'h60, 0); rdlit("R1", 'h64, 0);
    check("R1", 64'(irq), 0);
    rdlit("R2", 'h10, 0);

    // R5 / R9: counter 1 periodic on slow ticks, reload 3
    wr('h00, 3);
    wr('h08, 32'hC0);
    rdlit("R2", 'h00, 3);
    repeat (3) cyc(1, 0);
    rdlit("R5", 'h04, 0);
    check("R5", 64'(irq[0]), 0);
    cyc(1, 0);
    rdlit("R5", 'h04, 3);
    check("R5", 64'(irq[0]), 1);
    repeat (3) cyc(0, 1);
    rdlit("R9", 'h04, 3);
    repeat (8) cyc(1, 0);
    rd("R5", 'h04);

    // R7: clear, then clear in the same cycle as an underflow
    wr('h0C, 32'h1234);
    rdlit("R7", 'h04, 3);
    check("R7", 64'(irq[0]), 0);
    repeat (3) cyc(1, 0);
    wr('h0C, 0, 1, 0);
    rdlit("R7", 'h04, 3);
    check("R7", 64'(irq[0]), 1);
    wr('h0C, 0);
    rd("R7", 'h04);
    check("R7", 64'(irq[0]), 0);

    // R4 / R6: counter 2 free-run, fast; reload write beats a tick
    wr('h28, 32'h88);
    wr('h20, 2, 0, 1);
    rdlit("R4", 'h24, 2);
    repeat (3) cyc(0, 1);
    rdlit("R6", 'h24, 32'hFFF);
    check("R6", 64'(irq[1]), 1);

    // R8 / R11: masking and ignored writes
    wr('h20, 32'hFFFF_FFFF);
    rdlit("R8", 'h20, 32'hFFF);
    rdlit("R8", 'h24, 32'hFFF);
    wr('h24, 5);
    rdlit("R11", 'h24, 32'hFFF);

    // R3: stop bit and unused control bits
    wr('h28, 32'h48);
    repeat (4) cyc(1, 1);
    rdlit("R3", 'h24, 32'hFFF);
    rdlit("R3", 'h28, 32'h48);
    wr('h28, 32'hFF);
    rdlit("R3", 'h28, 32'hC8);
    wr('h28, 32'h00);

    // R8: wide counter 3
    wr('h80, 32'hFFFF_FFF0);
    rdlit("R8", 'h84, 32'hFFFF_FFF0);
    wr('h88, 32'hC8);
    repeat (5) cyc(0, 1);
    rdlit("R8", 'h84, 32'hFFFF_FFEB);

    // R10 / R11: long counter
    rdlit("R10", 'h60, 0);
    wr('h64, 32'h100);
    repeat (20) cyc(0, 1);
    repeat (4) cyc(1, 0);
    rdlit("R10", 'h60, 20);
    rdlit("R10", 'h64, 32'h100);
    wr('h60, 32'h1234, 0, 1);
    rdlit("R11", 'h60, 21);
    wr('h64, 32'hFF);
    cyc(0, 1);
    rdlit("R10", 'h64, 0);
    rdlit("R10", 'h60, 21);

    // mixed traffic against the model
    wr('h00, 5); wr('h08, 32'hC8);
    wr('h20, 2); wr('h28, 32'h80);
    wr('h80, 7); wr('h88, 32'hC0);
    wr('h64, 32'h100);
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:4] == 4'h0)      wr(gbase(int'(lfsr[9:8]) % 3) + 12, 0, lfsr[0], lfsr[1]);
      else if (lfsr[7:4] == 4'h1) wr(gbase(int'(lfsr[9:8]) % 3), 32'(lfsr[3:0]), lfsr[0], lfsr[1]);
      else                        cyc(lfsr[0], lfsr[1]);
      if (n % 15 == 0) begin
        for (int i = 0; i < 3; i++) rd("R5", gbase(i) + 4);
        rd("R10", 'h60);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule